// File: doc/BRIEF.md
# Byte-Wide Access Bridge for a 16-Bit Counter

This block sits between an 8-bit processor bus and a 16-bit free-running counter. The bus can move only one byte per access, but the counter changes every cycle. Reading the two halves separately could therefore mix bytes from two different counter values, and writing them separately could briefly load a half-written value. The bridge avoids both problems with one staging byte, called the hold byte, that serves both directions.

On a read, the low byte must be accessed first. That access returns the live low byte and, on the same clock edge, saves the live high byte in the hold byte. The later high-byte read returns the saved copy, so the pair describes one instant.

On a write, the low byte goes first and is only parked in the hold byte. The high-byte write then presents the whole 16-bit word to the counter together with a one-cycle load strobe.

Reads and writes share the hold byte. Any access that falls between the two halves of another sequence changes what the second half sees.

Top module: `acc16_bridge`

## Requirements
- R1: After reset, the hold byte is 0x00, `bus_rdata` is 0x00 and `cnt_load` is low.
- R2: A read with `bus_addr`=0 (the low byte) updates `bus_rdata` on the next clock edge to bits 7:0 of `cnt_live`. On that same edge, bits 15:8 of `cnt_live` are copied into the hold byte.
- R3: A read with `bus_addr`=1 (the high byte) updates `bus_rdata` on the next clock edge to the hold byte. After a low-byte read, this is the high byte as it stood at that earlier read, even if `cnt_live` has changed since.
- R4: A write with `bus_addr`=0 stores `bus_wdata` in the hold byte and raises no load strobe.
- R5: A write with `bus_addr`=1 drives `cnt_load` high from the next clock edge. `cnt_load_val` then equals {`bus_wdata`, hold byte}, with the written byte in bits 15:8.
- R6: `cnt_load` is high only in the cycle after a high-byte write and falls in the cycle after that.
- R7: The hold byte is shared. A low-byte read between a low-byte write and a high-byte write replaces the low half of the loaded word with the live high byte. A low-byte write between the two reads changes what the high-byte read returns.
- R8: A high-byte read not preceded by a low-byte read returns whatever the hold byte holds, for example the reset value or the last low-byte write.
- R9: When `bus_rd` and `bus_wr` are both high, only the write takes effect. A cycle without an accepted read leaves `bus_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Byte select: 0 low byte, 1 high byte |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| cnt_live | input | 16 | Current counter value |
| cnt_load_val | output | 16 | Word to load into the counter |
| cnt_load | output | 1 | One-cycle load strobe |

## Verification
Snapshot reads are tried with several counter values, and the counter value changes between the two halves. This tells a true snapshot apart from a live pass-through of the high byte. Writes are issued low-then-high with distinct byte values, which exposes byte-order swaps and premature loads. Interleaved sequences in both directions, an unpaired high read, and a cycle with both strobes high separate a shared hold byte from private ones and confirm the write-over-read priority.

// File: rtl/acc16_pkg.sv
package acc16_pkg;
  localparam int ACC_BYTE_W = 8;
  localparam int ACC_WORD_W = 2 * ACC_BYTE_W;

  function automatic logic [ACC_WORD_W-1:0] join_word(input logic [ACC_BYTE_W-1:0] hi,
                                                      input logic [ACC_BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [ACC_BYTE_W-1:0] upper_byte(input logic [ACC_WORD_W-1:0] w);
    return w[ACC_WORD_W-1 -: ACC_BYTE_W];
  endfunction

  function automatic logic [ACC_BYTE_W-1:0] lower_byte(input logic [ACC_WORD_W-1:0] w);
    return w[ACC_BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/acc16_hold_reg.sv
module acc16_hold_reg
  import acc16_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_live,
  input  logic                  cap_wr,
  input  logic [ACC_BYTE_W-1:0] live_hi,
  input  logic [ACC_BYTE_W-1:0] wr_byte,
  output logic [ACC_BYTE_W-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hold_q <= '0;
    else if (cap_wr)   hold_q <= wr_byte;
    else if (cap_live) hold_q <= live_hi;
  end

  AST_HOLD_FROM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_live && !cap_wr) |=> hold_q == $past(live_hi)); // R2
  AST_HOLD_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_wr |=> hold_q == $past(wr_byte)); // R4
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_wr && !cap_live) |=> $stable(hold_q)); // R7
endmodule

// File: rtl/acc16_rd_port.sv
module acc16_rd_port
  import acc16_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take_lo,
  input  logic                  take_hi,
  input  logic [ACC_BYTE_W-1:0] live_lo,
  input  logic [ACC_BYTE_W-1:0] hold_q,
  output logic [ACC_BYTE_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (take_lo) rdata <= live_lo;
    else if (take_hi) rdata <= hold_q;
  end

  AST_RD_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    take_hi |=> rdata == $past(hold_q)); // R3
  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_lo && !take_hi) |=> $stable(rdata)); // R9
endmodule

// File: rtl/acc16_wr_port.sv
module acc16_wr_port
  import acc16_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit,
  input  logic [ACC_BYTE_W-1:0] wr_byte,
  input  logic [ACC_BYTE_W-1:0] hold_q,
  output logic [ACC_WORD_W-1:0] load_val,
  output logic                  load
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load     <= 1'b0;
      load_val <= '0;
    end else begin
      load <= commit;
      if (commit) load_val <= join_word(wr_byte, hold_q);
    end
  end

  AST_LOAD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> $past(commit)); // R6
  AST_LOAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (load && lower_byte(load_val) == $past(hold_q))); // R5
endmodule

// File: rtl/acc16_bridge.sv
module acc16_bridge
  import acc16_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_addr,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [ACC_BYTE_W-1:0] bus_wdata,
  output logic [ACC_BYTE_W-1:0] bus_rdata,
  input  logic [ACC_WORD_W-1:0] cnt_live,
  output logic [ACC_WORD_W-1:0] cnt_load_val,
  output logic                  cnt_load
);
  localparam logic SEL_LO = 1'b0;
  localparam logic SEL_HI = 1'b1;

  // named access events
  logic ev_rd_lo, ev_rd_hi, ev_wr_lo, ev_wr_hi;
  logic [ACC_BYTE_W-1:0] hold_byte;

  assign ev_wr_lo = bus_wr && (bus_addr == SEL_LO);
  assign ev_wr_hi = bus_wr && (bus_addr == SEL_HI);
  assign ev_rd_lo = bus_rd && !bus_wr && (bus_addr == SEL_LO);
  assign ev_rd_hi = bus_rd && !bus_wr && (bus_addr == SEL_HI);

  acc16_hold_reg u_hold (
    .clk(clk), .rst_n(rst_n),
    .cap_live(ev_rd_lo), .cap_wr(ev_wr_lo),
    .live_hi(upper_byte(cnt_live)), .wr_byte(bus_wdata),
    .hold_q(hold_byte)
  );

  acc16_rd_port u_rd (
    .clk(clk), .rst_n(rst_n),
    .take_lo(ev_rd_lo), .take_hi(ev_rd_hi),
    .live_lo(lower_byte(cnt_live)), .hold_q(hold_byte),
    .rdata(bus_rdata)
  );

  acc16_wr_port u_wr (
    .clk(clk), .rst_n(rst_n),
    .commit(ev_wr_hi), .wr_byte(bus_wdata), .hold_q(hold_byte),
    .load_val(cnt_load_val), .load(cnt_load)
  );

  AST_LO_WR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr_lo && !ev_wr_hi) |=> !cnt_load); // R4
  AST_RD_LO_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_lo |=> bus_rdata == lower_byte($past(cnt_live))); // R2
  AST_LOAD_HIBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_hi |=> upper_byte(cnt_load_val) == $past(bus_wdata)); // R5
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rd_lo, ev_rd_hi, ev_wr_lo, ev_wr_hi})); // R9
endmodule

// File: tb/acc16_bridge_tb_top.sv
`timescale 1ns/1ps
module acc16_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [15:0] cnt_live = '0;
  logic [15:0] cnt_load_val;
  logic cnt_load;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  acc16_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_live(cnt_live), .cnt_load_val(cnt_load_val), .cnt_load(cnt_load)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle access; results sampled at the next falling edge
  task automatic access(input logic rd, input logic wr, input logic hi, input logic [7:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = hi; bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 rdata", {8'h0, bus_rdata}, 16'h0);
    check("R1 load", {15'h0, cnt_load}, 16'h0);
    access(1, 0, 1, 8'h00);
    check("R8/R1 unpaired high read after reset", {8'h0, bus_rdata}, 16'h0);
  endtask

  task automatic t_snapshot(input logic [15:0] a, input logic [15:0] b);
    cnt_live = a;
    access(1, 0, 0, 8'h00);
    check("R2 low read", {8'h0, bus_rdata}, {8'h0, a[7:0]});
    cnt_live = b;
    access(1, 0, 1, 8'h00);
    check("R3 high read snapshot", {8'h0, bus_rdata}, {8'h0, a[15:8]});
  endtask

  task automatic t_write(input logic [7:0] lo, input logic [7:0] hi);
    access(0, 1, 0, lo);
    check("R4 low write no load", {15'h0, cnt_load}, 16'h0);
    access(0, 1, 1, hi);
    check("R5 load strobe", {15'h0, cnt_load}, 16'h1);
    check("R5 load word", cnt_load_val, {hi, lo});
    @(negedge clk);
    check("R6 strobe falls", {15'h0, cnt_load}, 16'h0);
  endtask

  task automatic t_lo_write_seen();
    access(0, 1, 0, 8'h77);
    access(1, 0, 1, 8'h00);
    check("R8/R4 high read returns written byte", {8'h0, bus_rdata}, 16'h0077);
  endtask

  task automatic t_corrupt_write();
    access(0, 1, 0, 8'h11);
    cnt_live = 16'hEE22;
    access(1, 0, 0, 8'h00);
    access(0, 1, 1, 8'h99);
    check("R7 interleaved read corrupts write", cnt_load_val, 16'h99EE);
  endtask

  task automatic t_corrupt_read();
    cnt_live = 16'h4455;
    access(1, 0, 0, 8'h00);
    access(0, 1, 0, 8'h66);
    access(1, 0, 1, 8'h00);
    check("R7 interleaved write corrupts read", {8'h0, bus_rdata}, 16'h0066);
  endtask

  task automatic t_both();
    cnt_live = 16'hA1B2;
    access(1, 0, 0, 8'h00);
    cnt_live = 16'hC3D4;
    access(1, 1, 0, 8'h3C);
    check("R9 read ignored, rdata held", {8'h0, bus_rdata}, 16'h00B2);
    access(1, 0, 1, 8'h00);
    check("R9 write took effect", {8'h0, bus_rdata}, 16'h003C);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_snapshot(16'h12AB, 16'h3456);
        t_snapshot(16'hFF00, 16'h0000);
        t_snapshot(16'h00FF, 16'hFFFF);
        t_write(8'h5A, 8'hC3);
        t_write(8'hFF, 8'h01);
        t_lo_write_seen();
        t_corrupt_write();
        t_corrupt_read();
        t_both();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule